// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Match Alarm

This peripheral keeps wall-clock time as a 32-bit count of seconds. A prescaler divides the system clock into one pulse per second, and each pulse advances the count by one. When the count reaches 0xFFFF_FFFF, the next pulse takes it back to zero. Software sets the time by writing a new value into the count. It programs an alarm by writing a match value. The alarm is a single interrupt bit that can be masked and cleared, and a level interrupt line goes to the processor.

Access uses a simple two-phase APB-style bus with a setup cycle and an enable cycle. The block decodes a 4 KB window made of 32-bit words. The first eight word offsets hold the registers. The last eight words hold read-only identification bytes, one byte per word. The clock cannot be stopped: the control word always reads as enabled.

Top module: `secs_rtc`

## Requirements
- R1: The count rises by exactly one once every CLK_HZ clock cycles and holds its value between those steps. A load write restarts the prescaler, so the first step after a load happens CLK_HZ cycles after the load's commit edge.
- R2: A write to offset 0x08 sets the count to the written data on the commit edge, even when a second step falls on that same edge. Offset 0x00 reads the live count. Offset 0x08 reads as zero.
- R3: A step from 0xFFFF_FFFF gives 0x0000_0000.
- R4: Offset 0x04 holds the 32-bit match value and reads it back. Raw status bit 0 (offset 0x14) sets on the edge where a step makes the count equal the match value. This also works when the match value is below the count and is reached only after a wrap. A load never sets the status.
- R5: Any write to offset 0x1C clears raw status, whatever data is written. If a new match happens on the same edge as the clear, the status stays set.
- R6: Offset 0x10 bit 0 is the interrupt mask. Offset 0x18 bit 0 and the `irq` output both equal raw AND mask. Bits 31:1 of 0x10, 0x14 and 0x18 read as zero.
- R7: Offset 0x0C always reads 1. Writes to it change nothing.
- R8: Offsets 0xFE0 to 0xFFC read the bytes 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in ascending address order, each byte in bits 7:0 of its word.
- R9: A read of an unmapped or misaligned (paddr[1:0] not 0) address returns zero. A write to such an address, or to 0x00, 0x14, 0x18 or the identification words, leaves all state unchanged.
- R10: After reset, the count, match, mask and raw status are all zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Enable (second) phase of a transfer |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address within the 4 KB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from paddr |
| irq | output | 1 | Level interrupt, raw status AND mask |

## Verification
Two events can land on the same clock edge: a clear write and the count step that produces a new match. The bench loads the count to one below the match value. It then begins a clear write timed so that the write commits on the edge of the next step. On that edge, raw status and `irq` must stay high. A second clear write with no step must drop them. The bench also creates a second collision, a load that lands on a step edge, to check that the written value wins over the increment.

// File: rtl/secs_rtc.sv
module secs_rtc #(
  parameter int unsigned CLK_HZ = 32768
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [11:0] paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic        irq
);
  localparam int PW = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(CLK_HZ - 1);

  localparam logic [9:0] W_COUNT = 10'h000;
  localparam logic [9:0] W_MATCH = 10'h001;
  localparam logic [9:0] W_LOAD  = 10'h002;
  localparam logic [9:0] W_CTRL  = 10'h003;
  localparam logic [9:0] W_MASK  = 10'h004;
  localparam logic [9:0] W_RAW   = 10'h005;
  localparam logic [9:0] W_MSKD  = 10'h006;
  localparam logic [9:0] W_CLR   = 10'h007;

  logic [PW-1:0] pre;
  logic [31:0]   cnt, match_r, nxt;
  logic          mask_r, raw;
  logic          tick, set_ev;

  wire [9:0] widx    = paddr[11:2];
  wire       aligned = (paddr[1:0] == 2'b00);
  wire       wr      = psel && penable && pwrite && aligned;
  wire       wr_load  = wr && (widx == W_LOAD);
  wire       wr_match = wr && (widx == W_MATCH);
  wire       wr_mask  = wr && (widx == W_MASK);
  wire       wr_clr   = wr && (widx == W_CLR);

  assign tick   = (pre == PRE_LAST);
  assign nxt    = cnt + 32'd1;
  assign set_ev = tick && !wr_load && (nxt == match_r);
  assign irq    = raw & mask_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pre <= '0;
    else if (wr_load || tick)  pre <= '0;
    else                       pre <= pre + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (wr_load)  cnt <= pwdata;
    else if (tick)     cnt <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_r <= '0;
      mask_r  <= 1'b0;
    end else begin
      if (wr_match) match_r <= pwdata;
      if (wr_mask)  mask_r  <= pwdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       raw <= 1'b0;
    else if (set_ev)  raw <= 1'b1;
    else if (wr_clr)  raw <= 1'b0;
  end

  function automatic logic [7:0] id_byte(input logic [2:0] i);
    case (i)
      3'd0: id_byte = 8'h31;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h14;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

  always_comb begin
    prdata = '0;
    if (aligned) begin
      if (widx[9:3] == 7'h7F)
        prdata = {24'd0, id_byte(widx[2:0])};
      else case (widx)
        W_COUNT: prdata = cnt;
        W_MATCH: prdata = match_r;
        W_CTRL:  prdata = 32'd1;
        W_MASK:  prdata = {31'd0, mask_r};
        W_RAW:   prdata = {31'd0, raw};
        W_MSKD:  prdata = {31'd0, raw & mask_r};
        default: prdata = '0;
      endcase
    end
  end

  assert_prescale_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pre <= PRE_LAST);
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_load) |=> cnt == $past(cnt));
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_load) |=> cnt == $past(cnt) + 32'd1);
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_load |=> cnt == $past(pwdata));
  assert_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw) |-> (cnt == match_r) || $past(wr_match));
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !tick) |=> !raw);
endmodule

// File: tb/secs_rtc_bench.sv
module secs_rtc_bench;
  localparam int unsigned HZ = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  secs_rtc #(.CLK_HZ(HZ)) u_secs_rtc (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk); penable = 1'b1;
    @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    paddr = a; #1; d = prdata;
  endtask

  task automatic edges(input int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;

    rd(12'h000, d); chk("R10 count", d, 0);
    rd(12'h004, d); chk("R10 match", d, 0);
    rd(12'h010, d); chk("R10 mask", d, 0);
    rd(12'h014, d); chk("R10 raw", d, 0);
    rd(12'h018, d); chk("R10 masked", d, 0);
    chk("R10 irq", {31'd0, irq}, 0);
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      rd(12'hFE0 + 12'(i*4), d);
      chk("R8 id byte", d, {24'd0, 8'(i == 0 ? 8'h31 : i == 1 ? 8'h10 : i == 2 ? 8'h14 :
          i == 3 ? 8'h00 : i == 4 ? 8'h0D : i == 5 ? 8'hF0 : i == 6 ? 8'h05 : 8'hB1)});
    end
    rd(12'h008, d); chk("R2 load reads zero", d, 0);
    rd(12'h020, d); chk("R9 unmapped read", d, 0);
    rd(12'hFDC, d); chk("R9 unmapped read below id", d, 0);
    rd(12'h00D, d); chk("R9 misaligned read", d, 0);
    rd(12'h00C, d); chk("R7 ctrl reads one", d, 1);
    @(negedge clk);

    // R1 R2 R3: count sweep across several loaded values, including the wrap
    for (int v = 0; v < 4; v++) begin
      logic [31:0] base;
      base = (v == 0) ? 32'h0000_0000 : (v == 1) ? 32'h1234_5678 :
             (v == 2) ? 32'hFFFF_FFFD : 32'h8000_0000;
      wr(12'h008, base);
      rd(12'h000, d); chk("R2 load value", d, base);
      for (int k = 1; k <= 13; k++) begin
        edges(1);
        rd(12'h000, d); chk("R1 R3 count after k cycles", d, base + 32'(k / HZ));
      end
    end

    // R2: load lands on a step edge; loaded value wins
    wr(12'h008, 32'h0000_0100);
    edges(2);
    wr(12'h008, 32'h0000_0050);
    rd(12'h000, d); chk("R2 load beats step", d, 32'h50);
    edges(3); rd(12'h000, d); chk("R1 prescaler restarted", d, 32'h50);
    edges(1); rd(12'h000, d); chk("R1 first step after load", d, 32'h51);

    // R7: ctrl write has no effect
    wr(12'h00C, 32'h0);
    rd(12'h00C, d); chk("R7 ctrl still one", d, 1);
    wr(12'h008, 32'h10);
    edges(4); rd(12'h000, d); chk("R7 counter still runs", d, 32'h11);

    // R4 R6: match sweep with and without mask
    wr(12'h01C, 32'h0);
    for (int m = 0; m < 2; m++) begin
      wr(12'h010, 32'(m) | 32'hFFFF_FFFE);
      rd(12'h010, d); chk("R6 mask readback", d, 32'(m));
      wr(12'h004, 32'h0000_2000);
      rd(12'h004, d); chk("R4 match readback", d, 32'h2000);
      wr(12'h008, 32'h0000_1FFD);
      edges(11);
      rd(12'h014, d); chk("R4 raw before match", d, 0);
      edges(1);
      rd(12'h014, d); chk("R4 raw at match", d, 1);
      rd(12'h018, d); chk("R6 masked status", d, 32'(m));
      chk("R6 irq", {31'd0, irq}, 32'(m));
      wr(12'h01C, 32'h0);
      rd(12'h014, d); chk("R5 clear with zero data", d, 0);
      chk("R6 irq after clear", {31'd0, irq}, 0);
    end

    // R4: load equal to match does not set status
    wr(12'h008, 32'h0000_2000);
    edges(1);
    rd(12'h014, d); chk("R4 load sets nothing", d, 0);

    // R4 R3: match below count, reached after wrap
    wr(12'h004, 32'h0000_0001);
    wr(12'h008, 32'hFFFF_FFFF);
    edges(7); rd(12'h014, d); chk("R4 wrap not yet", d, 0);
    edges(1); rd(12'h014, d); chk("R4 wrap match", d, 1);
    rd(12'h000, d); chk("R3 wrapped count", d, 1);

    // R9: writes to read-only words and unmapped space are ignored
    wr(12'h014, 32'h0);
    rd(12'h014, d); chk("R9 raw write ignored", d, 1);
    wr(12'h018, 32'h0);
    rd(12'h018, d); chk("R9 masked write ignored", d, 1);
    wr(12'h024, 32'h0);
    wr(12'h005, 32'hFFFF);
    wr(12'hFE4, 32'h0);
    rd(12'h004, d); chk("R9 match untouched", d, 1);
    rd(12'h010, d); chk("R9 mask untouched", d, 1);
    rd(12'hFE4, d); chk("R9 id untouched", d, 32'h10);
    wr(12'h01F, 32'h1);
    rd(12'h014, d); chk("R9 misaligned clear ignored", d, 1);

    // R5: clear collides with new match; set wins
    wr(12'h01C, 32'h1);
    wr(12'h004, 32'h0000_0400);
    wr(12'h008, 32'h0000_03FF);
    edges(2);
    wr(12'h01C, 32'hDEAD_BEEF);
    rd(12'h014, d); chk("R5 set beats clear", d, 1);
    chk("R5 irq stays high", {31'd0, irq}, 1);
    wr(12'h01C, 32'h0);
    rd(12'h014, d); chk("R5 later clear", d, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule